// File: doc/BRIEF.md
# Sticky Conversion Status Register

This block holds the eight-bit status byte of a converter front end. Each completed conversion comes in as a signed result with a one-cycle valid strobe. The block classifies the result against two programmable signed thresholds and against zero, and latches the outcome into sticky flags. A low-supply comparator level is also latched. A data-ready flag records that a fresh result is waiting.

A host reads the byte through `stat_q` and pulses `stat_rd` in the cycle it samples it. That read clears the event flags. A flag survives the read if its condition still holds: the supply is still low, or the most recent completed conversion still meets the condition. Only a pulse on `result_rd`, which marks a read of the conversion result elsewhere, clears the data-ready flag. When a new conversion lands in the same cycle as a clearing read, the new event wins. One parameter builds a variant without the low-supply input, in which that flag is tied to zero.

Top module: `conv_status_reg`

## Requirements
- R1: After a synchronous reset `stat_q` is 0x00. Bit 7 is negative polarity, bit 6 is above-overrange, bit 5 is below-underrange, bit 4 is low supply and bit 3 is data ready. Bits 2..0 always read 0.
- R2: A valid conversion with a negative result sets bit 7, visible from the clock edge that samples `conv_valid`.
- R3: A valid conversion whose result is strictly greater than `over_thresh` sets bit 6. A result equal to the threshold does not set it.
- R4: A valid conversion whose result is strictly less than `under_thresh` sets bit 5. A result equal to the threshold does not set it.
- R5: Bit 4 is set at any clock edge where `low_supply` is high, independently of conversions.
- R6: A `stat_rd` pulse clears bits 7..4 at the next edge. The exceptions are bit 4 while `low_supply` is still high, and bits 7..5 whose condition is met by the most recent completed conversion.
- R7: Every valid conversion sets bit 3, and `stat_rd` has no effect on bit 3.
- R8: A `result_rd` pulse clears bit 3 at the next edge.
- R9: A new conversion or low-supply event in the same cycle as a clearing read leaves its flag set.
- R10: During the cycle in which `stat_rd` is high, `stat_q` still shows the flags as they stood before the read.
- R11: With `HAS_LOW_SUPPLY` = 0, bit 4 always reads 0 whatever `low_supply` does.
- R12: All threshold comparisons are signed two's complement on `RES_W` bits. For example, a result of -1 lies above a threshold of -5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | One-cycle strobe for a completed conversion |
| conv_result | input | RES_W | Signed conversion result |
| over_thresh | input | RES_W | Signed overrange threshold |
| under_thresh | input | RES_W | Signed underrange threshold |
| low_supply | input | 1 | Low-supply comparator level |
| stat_rd | input | 1 | Status byte read strobe |
| result_rd | input | 1 | Result read strobe, clears data ready |
| stat_q | output | 8 | Status byte |

## Verification
The properties assume that `conv_result` and both thresholds are stable and meaningful whenever `conv_valid` is high. They also assume that a read strobe marks exactly the cycle in which the host samples `stat_q`. The directed tasks change inputs only between clock edges. They hold the thresholds constant across each conversion and raise every strobe for a single cycle. The sequences are built so that each flag's clear is tried both with its condition still met and with it gone, including a read that coincides with a new conversion.

// File: rtl/conv_status_pkg.sv
package conv_status_pkg;

    localparam int STAT_W = 8;

    // Flag positions in the status byte; software decodes these.
    localparam int POS_SIGN  = 7;
    localparam int POS_OVER  = 6;
    localparam int POS_UNDER = 5;
    localparam int POS_LOW   = 4;
    localparam int POS_RDY   = 3;

    localparam int N_CONV_FLAGS = 3;

    // Outcome of classifying one conversion result.
    typedef struct packed {
        logic neg;
        logic above;
        logic below;
    } conv_evt_t;

    // Status byte, MSB first.
    typedef struct packed {
        logic       neg;
        logic       above;
        logic       below;
        logic       low;
        logic       rdy;
        logic [2:0] zero;
    } status_t;

    function automatic status_t pack_status(input conv_evt_t f, input logic low,
                                            input logic rdy);
        status_t s;
        s.neg   = f.neg;
        s.above = f.above;
        s.below = f.below;
        s.low   = low;
        s.rdy   = rdy;
        s.zero  = 3'b000;
        return s;
    endfunction

endpackage

// File: rtl/conv_status_classifier.sv
module conv_status_classifier
    import conv_status_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_valid,
    input  logic [RES_W-1:0] conv_result,
    input  logic [RES_W-1:0] over_thresh,
    input  logic [RES_W-1:0] under_thresh,
    output conv_evt_t        set_evt,
    output conv_evt_t        live_evt
);
    logic signed [RES_W-1:0] res_s, over_s, under_s;
    conv_evt_t now_evt;
    conv_evt_t last_evt;

    assign res_s   = conv_result;
    assign over_s  = over_thresh;
    assign under_s = under_thresh;

    always_comb begin
        now_evt.neg   = res_s < 0;
        now_evt.above = res_s > over_s;
        now_evt.below = res_s < under_s;
    end

    // Conditions of the most recent completed conversion.
    always_ff @(posedge clk) begin
        if (rst)
            last_evt <= '0;
        else if (conv_valid)
            last_evt <= now_evt;
    end

    assign set_evt  = conv_valid ? now_evt : '0;
    assign live_evt = last_evt;
endmodule

// File: rtl/conv_status_sticky.sv
module conv_status_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic keep_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (set_i)
            q <= 1'b1;
        else if (clr_i && !keep_i)
            q <= 1'b0;
    end
endmodule

// File: rtl/conv_status_reg.sv
module conv_status_reg
    import conv_status_pkg::*;
#(
    parameter int RES_W          = 16,
    parameter bit HAS_LOW_SUPPLY = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_valid,
    input  logic [RES_W-1:0] conv_result,
    input  logic [RES_W-1:0] over_thresh,
    input  logic [RES_W-1:0] under_thresh,
    input  logic             low_supply,
    input  logic             stat_rd,
    input  logic             result_rd,
    output logic [STAT_W-1:0] stat_q
);
    conv_evt_t set_evt, live_evt, flags;
    logic      low_flag, rdy_flag;
    status_t   status;

    conv_status_classifier #(.RES_W(RES_W)) u_class (
        .clk          (clk),
        .rst          (rst),
        .conv_valid   (conv_valid),
        .conv_result  (conv_result),
        .over_thresh  (over_thresh),
        .under_thresh (under_thresh),
        .set_evt      (set_evt),
        .live_evt     (live_evt)
    );

    logic [N_CONV_FLAGS-1:0] set_v, live_v, flag_v;
    assign set_v  = set_evt;
    assign live_v = live_evt;

    for (genvar i = 0; i < N_CONV_FLAGS; i++) begin : g_conv_flag
        conv_status_sticky u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[i]),
            .clr_i  (stat_rd),
            .keep_i (live_v[i]),
            .q      (flag_v[i])
        );
    end
    assign flags = flag_v;

    if (HAS_LOW_SUPPLY) begin : g_low
        conv_status_sticky u_low (
            .clk    (clk),
            .rst    (rst),
            .set_i  (low_supply),
            .clr_i  (stat_rd),
            .keep_i (low_supply),
            .q      (low_flag)
        );
    end else begin : g_no_low
        assign low_flag = 1'b0;
    end

    conv_status_sticky u_rdy (
        .clk    (clk),
        .rst    (rst),
        .set_i  (conv_valid),
        .clr_i  (result_rd),
        .keep_i (1'b0),
        .q      (rdy_flag)
    );

    assign status = pack_status(flags, low_flag, rdy_flag);
    assign stat_q = status;
endmodule

// File: rtl/conv_status_chk.sv
module conv_status_chk
    import conv_status_pkg::*;
#(
    parameter int RES_W          = 16,
    parameter bit HAS_LOW_SUPPLY = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             conv_valid,
    input logic [RES_W-1:0] conv_result,
    input logic [RES_W-1:0] over_thresh,
    input logic [RES_W-1:0] under_thresh,
    input logic             low_supply,
    input logic             stat_rd,
    input logic             result_rd,
    input logic [STAT_W-1:0] stat_q
);
    logic signed [RES_W-1:0] r_s, o_s, u_s;
    assign r_s = conv_result;
    assign o_s = over_thresh;
    assign u_s = under_thresh;

    // R1
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        stat_q[2:0] == 3'b000);

    // R2
    sign_set_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_valid && r_s < 0) |=> stat_q[POS_SIGN]);

    // R3
    over_set_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_valid && r_s > o_s) |=> stat_q[POS_OVER]);

    // R4
    under_set_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_valid && r_s < u_s) |=> stat_q[POS_UNDER]);

    // R5
    low_set_chk: assert property (@(posedge clk) disable iff (rst)
        (low_supply && HAS_LOW_SUPPLY) |=> stat_q[POS_LOW]);

    // R6
    sign_fall_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_q[POS_SIGN]) |-> $past(stat_rd));

    // R7
    rdy_kept_on_status_read_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !result_rd && stat_q[POS_RDY]) |=> stat_q[POS_RDY]);

    // R8
    rdy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (result_rd && !conv_valid) |=> !stat_q[POS_RDY]);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_valid && stat_rd && result_rd) |=> stat_q[POS_RDY]);

    // R11
    no_low_chk: assert property (@(posedge clk) disable iff (rst)
        !HAS_LOW_SUPPLY |-> !stat_q[POS_LOW]);
endmodule

bind conv_status_reg conv_status_chk #(
    .RES_W          (RES_W),
    .HAS_LOW_SUPPLY (HAS_LOW_SUPPLY)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .conv_valid   (conv_valid),
    .conv_result  (conv_result),
    .over_thresh  (over_thresh),
    .under_thresh (under_thresh),
    .low_supply   (low_supply),
    .stat_rd      (stat_rd),
    .result_rd    (result_rd),
    .stat_q       (stat_q)
);

// File: tb/conv_status_reg_tb.sv
module conv_status_reg_tb;
    localparam int RES_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             conv_valid;
    logic [RES_W-1:0] conv_result, over_thresh, under_thresh;
    logic             low_supply, stat_rd, result_rd;
    logic [7:0]       stat_q, stat_q_nl;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    conv_status_reg #(.RES_W(RES_W), .HAS_LOW_SUPPLY(1'b1)) u_dut (
        .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_result(conv_result),
        .over_thresh(over_thresh), .under_thresh(under_thresh),
        .low_supply(low_supply), .stat_rd(stat_rd), .result_rd(result_rd),
        .stat_q(stat_q));

    conv_status_reg #(.RES_W(RES_W), .HAS_LOW_SUPPLY(1'b0)) u_dut_nolow (
        .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_result(conv_result),
        .over_thresh(over_thresh), .under_thresh(under_thresh),
        .low_supply(low_supply), .stat_rd(stat_rd), .result_rd(result_rd),
        .stat_q(stat_q_nl));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: stat_q=%02h expected %02h", req, act, exp);
        end
    endtask

    // One clock; strobes drop right after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
        conv_valid = 1'b0;
        stat_rd    = 1'b0;
        result_rd  = 1'b0;
    endtask

    task automatic convert(input int val);
        conv_result = val[RES_W-1:0];
        conv_valid  = 1'b1;
        tick();
    endtask

    task automatic clear_all();
        convert(0);
        stat_rd   = 1'b1;
        result_rd = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        rst = 1'b1; conv_valid = 0; stat_rd = 0; result_rd = 0; low_supply = 0;
        conv_result = '0;
        over_thresh = 16'sd100; under_thresh = -16'sd100;
        tick(); tick();
        rst = 1'b0;
        tick();
        check("R1 reset", stat_q, 8'h00);
    endtask

    task automatic t_sign();
        convert(-3);
        check("R2/R7 negative result", stat_q, 8'h88);
        stat_rd = 1'b1;
        #1 check("R10 pre-read view", stat_q, 8'h88);
        tick();
        check("R6/R7 sign kept, ready kept", stat_q, 8'h88);
        result_rd = 1'b1; tick();
        check("R8 ready cleared", stat_q, 8'h80);
        convert(5);
        check("R2 sign sticky", stat_q, 8'h88);
        stat_rd = 1'b1; tick();
        check("R6 sign cleared", stat_q, 8'h08);
        result_rd = 1'b1; tick();
        check("R8 empty", stat_q, 8'h00);
    endtask

    task automatic t_over();
        convert(100);
        check("R3 equal no over", stat_q, 8'h08);
        convert(101);
        check("R3 over set", stat_q, 8'h48);
        stat_rd = 1'b1; result_rd = 1'b1; tick();
        check("R6 over kept", stat_q, 8'h40);
        clear_all();
        check("R6 over cleared", stat_q, 8'h00);
    endtask

    task automatic t_under();
        convert(-100);
        check("R4 equal no under", stat_q, 8'h88);
        convert(-101);
        check("R4 under set", stat_q, 8'hA8);
        clear_all();
        check("R6 under cleared", stat_q, 8'h00);
    endtask

    task automatic t_signed();
        over_thresh = -16'sd5;
        convert(-1);
        check("R12 signed over", stat_q, 8'hC8);
        over_thresh = 16'sd100;
        clear_all();
        check("R12 cleared", stat_q, 8'h00);
    endtask

    task automatic t_low();
        low_supply = 1'b1; tick();
        check("R5 low set", stat_q, 8'h10);
        check("R11 variant low", stat_q_nl, 8'h00);
        stat_rd = 1'b1; tick();
        check("R6 low kept", stat_q, 8'h10);
        low_supply = 1'b0; tick();
        check("R5 low sticky", stat_q, 8'h10);
        stat_rd = 1'b1; tick();
        check("R6 low cleared", stat_q, 8'h00);
    endtask

    task automatic t_priority();
        conv_result = -16'sd3; conv_valid = 1'b1; stat_rd = 1'b1; result_rd = 1'b1;
        tick();
        check("R9 set wins", stat_q, 8'h88);
        clear_all();
        check("R9 cleared", stat_q, 8'h00);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: stat_q=%02h expected run end", stat_q);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_sign();
        t_over();
        t_under();
        t_signed();
        t_low();
        t_priority();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule